// File: doc/BRIEF.md
# Tick Timer with Compare Channels and Watchdog Reset

This block is a memory-mapped timer. A prescaler divides the system clock down to a one-microsecond tick, and a 32-bit up-counter advances once per tick. The counter is compared against six match registers. When the counter holds a channel's match value at the moment of a tick, that channel's sticky status bit sets. An interrupt line reports any status bit whose enable is set. Software can copy the counter into a snapshot register, so it reads a value that does not move while it computes.

The highest-numbered channel can also serve as a watchdog. Software services the watchdog by taking a snapshot, adding a timeout in ticks, and writing the sum to that channel's match register. All compares use 32-bit modulo arithmetic. If the count reaches the match value while both the watchdog enable and that channel's interrupt enable are set, the block raises a reset request. The request stays high for a fixed number of system clocks.

Register offsets, using a 32-bit data port and byte addresses:

| Offset | Name | Access | Meaning |
|---|---|---|---|
| 0x00 | count | read | current counter value |
| 0x08 + 4·i | match i | read/write | compare value for channel i |
| 0x24 | int enable | read/write | bit i enables channel i |
| 0x28 | watchdog enable | read/write | bit 0 |
| 0x30 | snapshot trigger | write | bit 0 = 1 copies the counter |
| 0x34 | snapshot | read | counter value copied at the last trigger |
| 0x38 | status | read, write 1 to clear | bit i = channel i matched |

Top module: `tmr_wdog_top`

## Requirements
- R1: After reset the following hold:
  - the counter and the snapshot read 0.
  - every match register reads 0xFFFFFFFF.
  - the int enable register at 0x24, the watchdog enable at 0x28 and the status register at 0x38 read 0.
  - irq_o and wdog_rst_o are low.
- R2: The counter, read at offset 0x00, advances by exactly one every PRESC_DIV system clocks. It does not change between ticks.
- R3: A write with bit 0 set to offset 0x30 copies the counter into the snapshot register at 0x34. The snapshot keeps that value until the next such write.
- R4: Match register i is written and read back at offset 0x08 + 4·i.
- R5: Status bit i at offset 0x38 sets on the tick that occurs while the counter equals match i. It is still 0 while the counter holds the match value before that tick. Once set, it stays set.
- R6: Writing 1s to offset 0x38 clears exactly those status bits. Bits written as 0 keep their value.
- R7: The compare is an exact 32-bit equality test. A match value below the current count does not set status until the counter wraps.
- R8: irq_o is high when any status bit i is set together with int enable bit i, where bit i of offset 0x24 enables channel i. It is low otherwise.
- R9: A channel 5 match raises wdog_rst_o when watchdog enable bit 0 at 0x28 is 1 and int enable bit 5 is 1. The request rises in the same cycle the status bit sets and stays high for 16 system clocks.
- R10: No reset request is issued in any of these cases:
  - int enable bit 5 is clear.
  - the watchdog enable is clear.
  - the match is on any channel other than 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wen | input | 1 | register write strobe |
| reg_addr | input | AW | byte address of the register |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr (combinational) |
| irq_o | output | 1 | OR of enabled status bits |
| wdog_rst_o | output | 1 | watchdog reset request pulse |

## Verification
The bench targets the exact tick on which a match registers. It checks that status is still clear while the counter sits on the match value and set once the counter has moved past it. A design that compared against the next count, or used "greater or equal", would fire one tick early or fire at once on a match value already behind the counter.

The bench also checks three ways to get the watchdog wrong:
- raising the reset request when only one of the two enables is set.
- raising it on a non-watchdog channel.
- producing a pulse that is not exactly 16 clocks long.

Two more checks cover the write-1-to-clear status register and the snapshot. A status write that cleared every bit would lose pending matches from other channels. A snapshot that followed the counter would change between reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned DW = 32;
    localparam logic [7:0] A_COUNT  = 8'h00;
    localparam logic [7:0] A_MATCH0 = 8'h08;
    localparam logic [7:0] A_IEN    = 8'h24;
    localparam logic [7:0] A_WDEN   = 8'h28;
    localparam logic [7:0] A_LATCH  = 8'h30;
    localparam logic [7:0] A_SNAP   = 8'h34;
    localparam logic [7:0] A_STAT   = 8'h38;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int unsigned DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.pre == LAST) s_d.pre = '0;
        else                 s_d.pre = s_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = (s_q.pre == LAST);
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
    parameter int unsigned W = 32
) (
    input  logic         tick_i,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] match_i,
    output logic         hit_o
);
    // exact equality: wrap-around comes for free with modulo-2^W sums
    assign hit_o = tick_i && (count_i == match_i);
endmodule

// File: rtl/tmr_rst_pulse.sv
module tmr_rst_pulse #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic req_o
);
    localparam int unsigned CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trig_i)             s_d.cnt = CW'(LEN);
        else if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_o = (s_q.cnt != '0);

    // R9: a request starts only from a trigger and lasts past its first cycle
    assert_pulse_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(trig_i));
    assert_pulse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |=> req_o);
endmodule

// File: rtl/tmr_wdog_top.sv
module tmr_wdog_top
    import tmr_pkg::*;
#(
    parameter int unsigned PRESC_DIV = 200,
    parameter int unsigned NCH       = 6,
    parameter int unsigned WDOG_CH   = NCH - 1,
    parameter int unsigned RST_LEN   = 16,
    parameter int unsigned AW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wen,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq_o,
    output logic          wdog_rst_o
);
    localparam logic [AW-1:0] AD_COUNT = AW'(A_COUNT);
    localparam logic [AW-1:0] AD_IEN   = AW'(A_IEN);
    localparam logic [AW-1:0] AD_WDEN  = AW'(A_WDEN);
    localparam logic [AW-1:0] AD_LATCH = AW'(A_LATCH);
    localparam logic [AW-1:0] AD_SNAP  = AW'(A_SNAP);
    localparam logic [AW-1:0] AD_STAT  = AW'(A_STAT);

    typedef struct packed {
        logic [DW-1:0]          count;
        logic [DW-1:0]          snap;
        logic [NCH-1:0][DW-1:0] match;
        logic [NCH-1:0]         ien;
        logic [NCH-1:0]         stat;
        logic                   wden;
    } st_t;

    st_t            s_d, s_q;
    logic           tick;
    logic [NCH-1:0] hit;
    logic           wd_trig;

    tmr_tick_gen #(.DIV(PRESC_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        tmr_cmp_chan #(.W(DW)) u_cmp (
            .tick_i  (tick),
            .count_i (s_q.count),
            .match_i (s_q.match[g]),
            .hit_o   (hit[g])
        );
    end

    assign wd_trig = hit[WDOG_CH] && s_q.ien[WDOG_CH] && s_q.wden;

    tmr_rst_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (wd_trig),
        .req_o  (wdog_rst_o)
    );

    always_comb begin
        s_d = s_q;
        if (tick) s_d.count = s_q.count + 1'b1;
        if (reg_wen) begin
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr == AW'(int'(A_MATCH0) + 4 * i)) s_d.match[i] = reg_wdata;
            end
            if (reg_addr == AD_IEN)  s_d.ien  = reg_wdata[NCH-1:0];
            if (reg_addr == AD_WDEN) s_d.wden = reg_wdata[0];
            if (reg_addr == AD_LATCH && reg_wdata[0]) s_d.snap = s_q.count;
            if (reg_addr == AD_STAT) s_d.stat = s_q.stat & ~reg_wdata[NCH-1:0];
        end
        // a new match wins over a clear in the same cycle
        s_d.stat = s_d.stat | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.match <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AD_COUNT) reg_rdata = s_q.count;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == AW'(int'(A_MATCH0) + 4 * i)) reg_rdata = s_q.match[i];
        end
        if (reg_addr == AD_IEN)  reg_rdata = 32'(s_q.ien);
        if (reg_addr == AD_WDEN) reg_rdata = 32'(s_q.wden);
        if (reg_addr == AD_SNAP) reg_rdata = s_q.snap;
        if (reg_addr == AD_STAT) reg_rdata = 32'(s_q.stat);
    end

    assign irq_o = |(s_q.stat & s_q.ien);

    // R2: the counter only moves on a prescaler tick
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.count));
    // R3: snapshot only changes on a trigger write
    assert_snap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wen && reg_addr == AD_LATCH) |=> $stable(s_q.snap));
    // R6: without a status write no bit ever drops
    assert_stat_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wen && reg_addr == AD_STAT) |=> ((s_q.stat & $past(s_q.stat)) == $past(s_q.stat)));
    // R8: an interrupt needs at least one enable
    assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (s_q.ien != '0));
    // R10: a reset request needs both enables
    assert_rst_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst_o) |-> $past(s_q.wden && s_q.ien[WDOG_CH]));
endmodule

// File: tb/tb_tmr_wdog_top.sv
`timescale 1ns/100ps
module tb_tmr_wdog_top;
    import tmr_pkg::*;

    localparam int unsigned DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, wdog_rst_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    tmr_wdog_top #(.PRESC_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
    );

    typedef struct packed {
        logic [2:0] ch;
        logic [7:0] off;
        logic [5:0] ien;
        logic       wde;
        logic       exp_irq;
        logic       exp_rst;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 8'd3, 6'h01, 1'b0, 1'b1, 1'b0},
        '{3'd2, 8'd3, 6'h00, 1'b0, 1'b0, 1'b0},
        '{3'd5, 8'd3, 6'h20, 1'b1, 1'b1, 1'b1},
        '{3'd5, 8'd3, 6'h00, 1'b1, 1'b0, 1'b0},
        '{3'd5, 8'd4, 6'h20, 1'b0, 1'b1, 1'b0},
        '{3'd3, 8'd4, 6'h3F, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cnt(input logic [31:0] t);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            @(negedge clk);
            rd(A_COUNT, v);
            n++;
        end while (v !== t && n < 2000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, l1, l2, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, read before the first tick
        rd(A_COUNT, v); chk("R1 count", v, 32'h0);
        for (int i = 0; i < 6; i++) begin
            rd(8'(int'(A_MATCH0) + 4 * i), v); chk("R1 match", v, 32'hFFFF_FFFF);
        end
        rd(A_IEN, v);  chk("R1 ien", v, 32'h0);
        rd(A_WDEN, v); chk("R1 wden", v, 32'h0);
        rd(A_STAT, v); chk("R1 stat", v, 32'h0);
        rd(A_SNAP, v); chk("R1 snap", v, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        chk("R1 rst", {31'h0, wdog_rst_o}, 32'h0);

        // R2: 40 clocks between two snapshots is 10 ticks
        wr(A_LATCH, 32'h1); rd(A_SNAP, l1);
        repeat (38) @(negedge clk);
        wr(A_LATCH, 32'h1); rd(A_SNAP, l2);
        chk("R2 tick rate", l2 - l1, 32'd10);

        // R3: snapshot holds while the counter moves
        repeat (30) @(negedge clk);
        rd(A_SNAP, v); chk("R3 snap hold", v, l2);
        rd(A_COUNT, v); chk("R3 count moved", {31'h0, v != l2}, 32'h1);

        // R4: match register read-back
        wr(8'(int'(A_MATCH0) + 8), 32'h1234_5678);
        rd(8'(int'(A_MATCH0) + 8), v); chk("R4 match2 rw", v, 32'h1234_5678);
        wr(8'(int'(A_MATCH0) + 8), 32'hFFFF_FFFF);

        // vector table: R5, R8, R9, R10
        foreach (VECS[k]) begin
            wr(A_IEN, 32'(VECS[k].ien));
            wr(A_WDEN, 32'(VECS[k].wde));
            wr(A_LATCH, 32'h1); rd(A_SNAP, l1);
            m = l1 + 32'(VECS[k].off);
            wr(8'(int'(A_MATCH0) + 4 * int'(VECS[k].ch)), m);
            wait_cnt(m);
            rd(A_STAT, v); chk("R5 not yet", v, 32'h0);
            wait_cnt(m + 1);
            rd(A_STAT, v); chk("R5 stat set", v, 32'h1 << VECS[k].ch);
            chk("R8 irq", {31'h0, irq_o}, {31'h0, VECS[k].exp_irq});
            chk("R9 R10 rst", {31'h0, wdog_rst_o}, {31'h0, VECS[k].exp_rst});
            wr(8'(int'(A_MATCH0) + 4 * int'(VECS[k].ch)), 32'hFFFF_FFFF);
            wr(A_STAT, 32'h3F);
            wr(A_IEN, 32'h0);
            wr(A_WDEN, 32'h0);
            repeat (20) @(negedge clk);
            rd(A_STAT, v); chk("R6 cleared", v, 32'h0);
        end

        // R7: match behind the counter never fires
        wr(A_LATCH, 32'h1); rd(A_SNAP, l1);
        wr(8'(int'(A_MATCH0) + 4), l1 - 1);
        repeat (40) @(negedge clk);
        rd(A_STAT, v); chk("R7 no match behind", v, 32'h0);
        wr(8'(int'(A_MATCH0) + 4), 32'hFFFF_FFFF);

        // R6: selective write-1-to-clear
        wr(A_LATCH, 32'h1); rd(A_SNAP, l1);
        wr(8'(int'(A_MATCH0)), l1 + 4);
        wr(8'(int'(A_MATCH0) + 4), l1 + 4);
        wait_cnt(l1 + 6);
        rd(A_STAT, v); chk("R6 both set", v, 32'h3);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R6 only bit0 cleared", v, 32'h2);
        wr(8'(int'(A_MATCH0)), 32'hFFFF_FFFF);
        wr(8'(int'(A_MATCH0) + 4), 32'hFFFF_FFFF);
        wr(A_STAT, 32'h3F);

        // R9: pulse length
        wr(A_IEN, 32'h20); wr(A_WDEN, 32'h1);
        wr(A_LATCH, 32'h1); rd(A_SNAP, l1);
        wr(8'(int'(A_MATCH0) + 20), l1 + 4);
        wait_cnt(l1 + 5);
        begin
            int hi;
            hi = 0;
            while (wdog_rst_o === 1'b1 && hi < 100) begin
                hi++;
                @(negedge clk);
            end
            chk("R9 pulse length", 32'(hi), 32'd16);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule